// File: doc/BRIEF.md
# Memory Host-Port Self-Test Master

This block is a self-test master for a burst-oriented memory host port. A one-cycle `start` pulse carries a base word address and a length in words. The block then writes a test pattern into every word of that range, reads the same range back, and compares each returned word with the pattern computed again from its address. While the run is in progress, `busy` is high. When the read-back ends, `done` pulses for one cycle. A sticky error flag and a saturating mismatch count hold their values until the next accepted start.

The host port works in two phases. In the issue phase, the block raises `req_valid` together with the direction and the start address. It holds all three until the memory side answers with `req_ready`. This is the only back-pressure on the port. The data phase begins in the cycle after that acknowledge. The memory side paces it with `beat_en`, and the block has no ready signal there:
- On a write, the word on `wdata` is taken in every cycle where `beat_en` is high and `beat_stop` is low.
- On a read, `rdata` is consumed in every such cycle.

`beat_en` may drop at any cycle, and the block simply waits. The block ends a transaction by holding `beat_stop` high. The transaction closes at the first cycle in which `beat_en` is high while `beat_stop` is high. No word moves in that cycle.

The block stops a transaction in two cases: after `BURST_MAX` beats, because it models a master that cannot sustain longer bursts, and when the phase has no words left. If words remain, it then issues a new transaction from the next address.

Top module: `mem_bist_master`

## Requirements
- R1: After reset, `busy`, `done`, `req_valid`, `beat_stop` and `err_flag` are 0, and `err_cnt` is 0.
- R2: Once raised, `req_valid` stays high with `req_write` and `req_addr` unchanged until the cycle in which `req_ready` is high. The first issue of a run is a write (`req_write`=1) at the base address.
- R3: Each write beat carries the pattern `{PAT_HI, addr[7:0]}`, where `addr` is the word address the beat lands on. With the defaults, the upper byte is 0xA5.
- R4: A moving beat advances the address by one, modulo 2^24. Cycles without `beat_en` move nothing, and the block waits through them without limit.
- R5: No transaction moves more than `BURST_MAX` (default 8) words. Every reissue starts at the address that follows the last word moved. `beat_stop` stays high across gaps until the transaction closes.
- R6: After exactly `len` words have been written, the block issues reads (`req_write`=0) starting at the base address, and it reads exactly `len` words.
- R7: Every read word that differs from the expected pattern adds one to `err_cnt`, which saturates at all ones. `err_flag` is set whenever `err_cnt` is nonzero. Both are cleared by an accepted start.
- R8: `busy` is high from the cycle after an accepted start until the read phase closes. `done` is high for exactly one cycle, in the cycle after that close, and `busy` is low in that cycle.
- R9: A `start` pulse while `busy` is high has no effect on the run's addresses, lengths or results, and no further issue follows the run.
- R10: A start with `len` = 0 produces a `done` pulse in the next cycle without raising `busy` or issuing any transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request pulse, honoured only when idle |
| start_addr | input | 24 | Base word address of the run |
| start_len | input | 24 | Number of words in the run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_flag | output | 1 | Sticky mismatch indicator |
| err_cnt | output | 16 | Saturating count of mismatched read words |
| req_valid | output | 1 | Issue request |
| req_write | output | 1 | Issue direction, 1 means write |
| req_addr | output | 24 | Issue start address |
| req_ready | input | 1 | Issue acknowledge from the memory side |
| beat_en | input | 1 | Data-phase strobe from the memory side |
| beat_stop | output | 1 | Terminate the current transaction |
| wdata | output | 16 | Write word, valid whenever `beat_en` may be high |
| rdata | input | 16 | Read word, valid in read beats |

## Verification
Directed runs with no gaps and an immediate acknowledge show the pure burst-cap rhythm. In that setting, every reissue falls exactly on a multiple of `BURST_MAX` words. Randomly gapped strobes, with up to 70 % dead cycles and random acknowledge delays, show whether the address and the pending stop survive idle cycles at every possible point, including right at the cap.

Runs that cross the top of the 24-bit address space exercise the wrap. Lengths of 0 and 1 exercise the degenerate sequencing. Read faults injected at addresses chosen by a modulus separate a correct mismatch count from one that misses or double-counts words. A start pulse placed in mid-run shows whether the block latches anything while busy.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_DATA  = 2'd2
  } seq_state_t;

endpackage

// File: rtl/mbist_pattern_gen.sv
module mbist_pattern_gen #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-9:0] PAT_HI = '1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] word
);
  // upper part fixed, low byte follows the address so read-back can regenerate it
  assign word = {PAT_HI, addr[7:0]};
endmodule

// File: rtl/mbist_checker.sv
module mbist_checker #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic [DATA_W-1:0] got,
  input  logic [DATA_W-1:0] want,
  output logic              err_flag,
  output logic [CNT_W-1:0]  err_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic miss;
  assign miss = sample && (got != want);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_cnt  <= '0;
    end else if (clear) begin
      err_flag <= 1'b0;
      err_cnt  <= '0;
    end else if (miss) begin
      err_flag <= 1'b1;
      if (err_cnt != CNT_MAX) err_cnt <= err_cnt + 1'b1;
    end
  end

  AST_FLAG_WITH_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != '0) |-> err_flag); // R7
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (err_cnt >= $past(err_cnt))); // R7
endmodule

// File: rtl/mbist_sequencer.sv
module mbist_sequencer
  import mbist_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int LEN_W     = 24,
  parameter int BURST_MAX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              req_ready,
  input  logic              beat_en,
  output logic              beat_stop,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              rd_beat,
  output logic              run_clear,
  output logic              busy,
  output logic              done
);
  localparam int BC_W = $clog2(BURST_MAX + 1);
  localparam logic [BC_W-1:0] BC_CAP = BC_W'(BURST_MAX);

  seq_state_t        state_q;
  logic [ADDR_W-1:0] base_q, addr_q;
  logic [LEN_W-1:0]  len_q, left_q;
  logic [BC_W-1:0]   burst_q;
  logic              wr_phase_q, done_q;

  logic accept, want_stop, move, close;

  assign accept    = start && (state_q == SEQ_IDLE);
  assign want_stop = (left_q == '0) || (burst_q == BC_CAP);
  assign move      = (state_q == SEQ_DATA) && beat_en && !want_stop;
  assign close     = (state_q == SEQ_DATA) && beat_en && want_stop;

  assign req_valid = (state_q == SEQ_ISSUE);
  assign req_write = wr_phase_q;
  assign req_addr  = addr_q;
  assign beat_stop = (state_q == SEQ_DATA) && want_stop;
  assign cur_addr  = addr_q;
  assign rd_beat   = move && !wr_phase_q;
  assign run_clear = accept;
  assign busy      = (state_q != SEQ_IDLE);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      base_q     <= '0;
      addr_q     <= '0;
      len_q      <= '0;
      left_q     <= '0;
      burst_q    <= '0;
      wr_phase_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (accept) begin
            base_q     <= start_addr;
            addr_q     <= start_addr;
            len_q      <= start_len;
            left_q     <= start_len;
            wr_phase_q <= 1'b1;
            if (start_len == '0) done_q  <= 1'b1;
            else                 state_q <= SEQ_ISSUE;
          end
        end
        SEQ_ISSUE: begin
          if (req_ready) begin
            state_q <= SEQ_DATA;
            burst_q <= '0;
          end
        end
        SEQ_DATA: begin
          if (move) begin
            addr_q  <= addr_q + 1'b1;
            left_q  <= left_q - 1'b1;
            burst_q <= burst_q + 1'b1;
          end else if (close) begin
            if (left_q != '0) begin
              state_q <= SEQ_ISSUE;
            end else if (wr_phase_q) begin
              wr_phase_q <= 1'b0;
              addr_q     <= base_q;
              left_q     <= len_q;
              state_q    <= SEQ_ISSUE;
            end else begin
              state_q <= SEQ_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write))); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    move |=> (addr_q == $past(addr_q) + 1'b1)); // R4
  AST_STOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_stop && !beat_en) |=> beat_stop); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(base_q) && $stable(len_q))); // R9
endmodule

// File: rtl/mem_bist_master.sv
module mem_bist_master #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int LEN_W     = 24,
  parameter int CNT_W     = 16,
  parameter int BURST_MAX = 8,
  parameter logic [DATA_W-9:0] PAT_HI = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  output logic              busy,
  output logic              done,
  output logic              err_flag,
  output logic [CNT_W-1:0]  err_cnt,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              req_ready,
  input  logic              beat_en,
  output logic              beat_stop,
  output logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata
);
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] pat_word;
  logic              rd_beat, run_clear;

  mbist_sequencer #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_MAX(BURST_MAX)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_addr(start_addr), .start_len(start_len),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_ready(req_ready), .beat_en(beat_en), .beat_stop(beat_stop),
    .cur_addr(cur_addr), .rd_beat(rd_beat), .run_clear(run_clear),
    .busy(busy), .done(done)
  );

  mbist_pattern_gen #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAT_HI(PAT_HI)
  ) u_pat (
    .addr(cur_addr), .word(pat_word)
  );

  assign wdata = pat_word;

  mbist_checker #(
    .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_chk (
    .clk(clk), .rst_n(rst_n), .clear(run_clear), .sample(rd_beat),
    .got(rdata), .want(pat_word), .err_flag(err_flag), .err_cnt(err_cnt)
  );
endmodule

// File: tb/tb_mem_bist_master.sv
module tb_mem_bist_master;
  localparam int BMAX = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic [23:0] start_len = '0;
  logic        busy, done, err_flag;
  logic [15:0] err_cnt;
  logic        req_valid, req_write;
  logic [23:0] req_addr;
  logic        req_ready = 1'b0;
  logic        beat_en = 1'b0;
  logic        beat_stop;
  logic [15:0] wdata;
  logic [15:0] rdata = '0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] mem [0:1023];

  always #4 clk = ~clk;

  mem_bist_master dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_len(start_len), .busy(busy), .done(done), .err_flag(err_flag),
    .err_cnt(err_cnt), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(req_ready), .beat_en(beat_en),
    .beat_stop(beat_stop), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [15:0] pat(input logic [23:0] a);
    return {8'hA5, a[7:0]};
  endfunction

  function automatic bit is_fault(input logic [23:0] a, input int fm, input int fs);
    return (fm != 0) && ((a % fm) == fs);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one full run against a behavioural memory side
  task automatic run(input logic [23:0] base, input int len, input int gap_pct,
                     input int fm, input int fs, input int poke_at);
    int rs = 0, ack_wait = 0, beats = 0, wr_moved = 0, rd_moved = 0;
    int exp_err = 0, cyc = 0;
    bit rwr = 1'b0, busy_bad = 1'b0, got_done = 1'b0;
    logic [23:0] raddr = '0, exp_a;
    @(negedge clk);
    start = 1'b1; start_addr = base; start_len = 24'(len);
    ack_wait = int'($urandom % 4);
    while (!got_done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      start = (cyc == poke_at);
      start_addr = 24'h000300; start_len = 24'd5;
      if (cyc > poke_at + 1) begin start_addr = base; start_len = 24'(len); end
      if (rs == 0) begin
        beat_en = 1'b0;
        req_ready = req_valid && (ack_wait == 0);
      end else begin
        req_ready = 1'b0;
        beat_en = (int'($urandom % 100) >= gap_pct);
        rdata = mem[raddr[9:0]] ^ ((!rwr && is_fault(raddr, fm, fs)) ? 16'h0100 : 16'h0000);
      end
      #3;
      if (!done && !busy) busy_bad = 1'b1;
      if (rs == 0 && req_valid) begin
        if (req_ready) begin
          exp_a = (wr_moved < len) ? 24'(base + 24'(wr_moved)) : 24'(base + 24'(rd_moved));
          check(req_addr == exp_a, "R5 reissue address", req_addr, exp_a);
          check(req_write == (wr_moved < len), "R6 issue direction", req_write, (wr_moved < len));
          rs = 1; raddr = req_addr; rwr = req_write; beats = 0;
        end else if (ack_wait > 0) ack_wait--;
      end else if (rs == 1 && beat_en) begin
        if (beat_stop) begin
          check(beats <= BMAX, "R5 burst length", beats, BMAX);
          rs = 0; ack_wait = int'($urandom % 4);
        end else begin
          if (beats >= BMAX) check(1'b0, "R5 beat beyond cap", beats, BMAX);
          if (rwr) begin
            check(wdata == pat(raddr), "R3 write pattern", wdata, pat(raddr));
            if (wr_moved >= len) check(1'b0, "R6 extra write", wr_moved, len);
            mem[raddr[9:0]] = wdata;
            wr_moved++;
          end else begin
            if (rd_moved >= len) check(1'b0, "R6 extra read", rd_moved, len);
            if (is_fault(raddr, fm, fs)) exp_err++;
            rd_moved++;
          end
          raddr = raddr + 24'd1; // R4 wrap at 2^24
          beats++;
        end
      end
      if (done) begin
        got_done = 1'b1;
        check(!busy, "R8 busy low at done", busy, 0);
        check(wr_moved == len && rd_moved == len, "R6 words moved", wr_moved + rd_moved, 2 * len);
        check(err_cnt == 16'(exp_err), "R7 mismatch count", err_cnt, exp_err);
        check(err_flag == (exp_err != 0), "R7 error flag", err_flag, (exp_err != 0));
        check(!busy_bad, "R8 busy during run", busy_bad, 0);
      end
    end
    if (!got_done) check(1'b0, "R8 run never finished", cyc, 0);
    beat_en = 1'b0; req_ready = 1'b0;
    @(negedge clk); #3;
    check(!done, "R8 done single cycle", done, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #3;
      check(!req_valid, "R9 no issue after run", req_valid, 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    #3;
    check(!busy && !done && !req_valid && !beat_stop, "R1 reset controls",
          {busy, done, req_valid, beat_stop}, 0);
    check(!err_flag && err_cnt == 0, "R1 reset status", err_cnt, 0);
    @(negedge clk); rst_n = 1'b1;
    // R2 R3 R5: gapless, immediate bursts
    run(24'h000010, 20, 0, 0, 0, -1);
    // R4: heavy gaps and a wrap across the top of the address space
    run(24'hFFFFF8, 30, 40, 7, 3, -1);
    // R6 R10 style degenerate length 1
    run(24'h000123, 1, 20, 1, 0, -1);
    // R9: start pulse mid-run
    run(24'h000040, 40, 30, 5, 2, 25);
    for (int k = 0; k < 8; k++) begin
      run(24'($urandom), 1 + int'($urandom % 60), int'($urandom % 70),
          int'($urandom % 9), int'($urandom % 3), -1);
    end
    // R10: zero length
    @(negedge clk); start = 1'b1; start_addr = 24'h000200; start_len = 24'd0;
    @(negedge clk); start = 1'b0; #3;
    check(done && !busy, "R10 zero length done", {done, busy}, 2'b10);
    check(!req_valid, "R10 no issue", req_valid, 0);
    check(err_cnt == 0 && !err_flag, "R7 cleared by start", err_cnt, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule